// File: doc/BRIEF.md
# Exception Entry State Save

This block applies the architectural register update that happens when the core takes an exception. The exception selector raises a one-cycle take strobe. With it come the vector offset of the chosen exception, the address of the instruction that would have completed next, and the current machine state word. On that clock edge the block does four things. It captures the return address in the first save/restore register. It stores the low half of the machine state in the second save/restore register. It forces a new machine state word. It computes the fetch address of the handler.

The handler address is the vector offset added to one of two physical bases. The interrupt-prefix bit of the incoming machine state selects the base. A valid output pulses for one cycle with each captured strobe, so the fetch unit can redirect. Choosing which exception to take, and returning from the handler, belong to other blocks.

Machine state bits are numbered big-endian. Bit 0 is the most significant bit and bit 31 is the least significant, so big-endian bit k sits at vector index 31-k.

Top module: `exc_entry_save`

## Requirements
- R1: After reset, msrOut, srr0, srr1 and redirAddr are all zero, and redirValid is low.
- R2: When takeExc is high at a rising edge, srr0 holds retAddr from the cycle after that edge.
- R3: On a taken strobe, srr1 big-endian bits 0-15 (vector [31:16]) become zero. Big-endian bits 16-31 (vector [15:0]) take msrIn big-endian bits 16-31 (vector [15:0]).
- R4: On a taken strobe, msrOut clears twelve bits, given here as big-endian bit (vector index). They are: power-save 13 (18), alternate-GPR 14 (17), external-enable 16 (15), problem-state 17 (14), float-available 18 (13), float-mode-0 20 (11), single-step 21 (10), branch-trace 22 (9), float-mode-1 23 (8), instruction-relocate 26 (5), data-relocate 27 (4), recoverable 30 (1). Together these form mask 0x0006EF32.
- R5: On a taken strobe, msrOut keeps interrupt-little-endian 15 (index 16), interrupt-prefix 25 (index 6) and machine-check-enable 19 (index 12) from msrIn. Its little-endian bit 31 (index 0) is set to msrIn's interrupt-little-endian bit.
- R6: On a taken strobe, msrOut copies unchanged every msrIn bit that R4 and R5 do not name (big-endian 0-12, 24, 28, 29).
- R7: On a taken strobe with msrIn interrupt-prefix bit (index 6) set, redirAddr becomes 0xFFF00000 plus the zero-extended vecOffset.
- R8: On a taken strobe with the interrupt-prefix bit clear, redirAddr becomes 0x00000000 plus the zero-extended vecOffset.
- R9: redirValid is high in exactly the cycle after each cycle in which takeExc is high, and low in every other cycle. Back-to-back strobes give back-to-back pulses, each carrying the values of its own strobe.
- R10: While takeExc is low, msrOut, srr0, srr1 and redirAddr hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| takeExc | input | 1 | Take-exception strobe |
| vecOffset | input | VEC_W (20) | Vector offset of the exception being taken |
| retAddr | input | ADDR_W (32) | Address of the next instruction to complete |
| msrIn | input | 32 | Current machine state word |
| msrOut | output | 32 | Forced machine state word |
| srr0 | output | ADDR_W (32) | Saved return address |
| srr1 | output | 32 | Saved low half of the machine state |
| redirAddr | output | ADDR_W (32) | Handler fetch address |
| redirValid | output | 1 | One-cycle redirect pulse |

## Verification
The bench builds the block with its default values: ADDR_W 32, VEC_W 20, a high base of 0xFFF00000 and a low base of zero. With a 20-bit offset, the largest offset under the high base reaches 0xFFFFFFFF exactly, which exercises the top of the address range without a carry out. The chosen machine state patterns include all-ones, alternating bits, and a word with the endian bit set but the interrupt-endian bit clear. Together they separate every cleared, kept, copied and passed-through bit position.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int MSR_W  = 32;
  localparam int SAVE_W = MSR_W / 2;

  // big-endian bit positions of the named machine state fields
  localparam int BE_POW  = 13;
  localparam int BE_TGPR = 14;
  localparam int BE_ILE  = 15;
  localparam int BE_EE   = 16;
  localparam int BE_PR   = 17;
  localparam int BE_FP   = 18;
  localparam int BE_ME   = 19;
  localparam int BE_FE0  = 20;
  localparam int BE_SE   = 21;
  localparam int BE_BE   = 22;
  localparam int BE_FE1  = 23;
  localparam int BE_IP   = 25;
  localparam int BE_IR   = 26;
  localparam int BE_DR   = 27;
  localparam int BE_RI   = 30;
  localparam int BE_LE   = 31;

  function automatic int leIdx(input int be);
    return MSR_W - 1 - be;
  endfunction

  typedef enum logic [1:0] {BIT_KEEP, BIT_CLEAR, BIT_FROM_ILE} bitAct_t;

  function automatic bitAct_t bitAction(input int idx);
    int be;
    be = leIdx(idx);
    if (be == BE_LE) return BIT_FROM_ILE;
    if (be == BE_POW || be == BE_TGPR || be == BE_EE || be == BE_PR ||
        be == BE_FP  || be == BE_FE0  || be == BE_SE || be == BE_BE ||
        be == BE_FE1 || be == BE_IR   || be == BE_DR || be == BE_RI)
      return BIT_CLEAR;
    return BIT_KEEP;
  endfunction

  typedef struct packed {
    logic loadState;
    logic loadRedir;
  } entryCtl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      takeExc,
  output entryCtl_t ctl,
  output logic      redirValid
);
  logic validQ;

  always_comb begin
    ctl.loadState = takeExc;
    ctl.loadRedir = takeExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= takeExc;
  end

  assign redirValid = validQ;
endmodule

// File: rtl/exc_entry_dpath.sv
module exc_entry_dpath
  import exc_entry_pkg::*;
#(
  parameter int              ADDR_W  = 32,
  parameter int              VEC_W   = 20,
  parameter logic [ADDR_W-1:0] BASE_HI = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] BASE_LO = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryCtl_t         ctl,
  input  logic [VEC_W-1:0]  vecOffset,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [MSR_W-1:0]  msrIn,
  output logic [MSR_W-1:0]  msrOut,
  output logic [ADDR_W-1:0] srr0,
  output logic [MSR_W-1:0]  srr1,
  output logic [ADDR_W-1:0] redirAddr
);
  localparam int ILE_I = leIdx(BE_ILE);
  localparam int IP_I  = leIdx(BE_IP);
  localparam int PAD_W = ADDR_W - VEC_W;

  logic [MSR_W-1:0]  nextMsr;
  logic [MSR_W-1:0]  nextSrr1;
  logic [ADDR_W-1:0] nextRedir;
  logic [ADDR_W-1:0] base;

  for (genvar i = 0; i < MSR_W; i++) begin : g_bit
    localparam bitAct_t ACT = bitAction(i);
    if (ACT == BIT_CLEAR) begin : g_clr
      assign nextMsr[i] = 1'b0;
    end else if (ACT == BIT_FROM_ILE) begin : g_ile
      assign nextMsr[i] = msrIn[ILE_I];
    end else begin : g_keep
      assign nextMsr[i] = msrIn[i];
    end
  end

  assign nextSrr1  = {{(MSR_W-SAVE_W){1'b0}}, msrIn[SAVE_W-1:0]};
  assign base      = msrIn[IP_I] ? BASE_HI : BASE_LO;
  assign nextRedir = base + {{PAD_W{1'b0}}, vecOffset};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msrOut <= '0;
      srr0   <= '0;
      srr1   <= '0;
    end else if (ctl.loadState) begin
      msrOut <= nextMsr;
      srr0   <= retAddr;
      srr1   <= nextSrr1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              redirAddr <= '0;
    else if (ctl.loadRedir) redirAddr <= nextRedir;
  end
endmodule

// File: rtl/exc_entry_save.sv
module exc_entry_save
  import exc_entry_pkg::*;
#(
  parameter int              ADDR_W  = 32,
  parameter int              VEC_W   = 20,
  parameter logic [ADDR_W-1:0] BASE_HI = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] BASE_LO = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              takeExc,
  input  logic [VEC_W-1:0]  vecOffset,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [31:0]       msrIn,
  output logic [31:0]       msrOut,
  output logic [ADDR_W-1:0] srr0,
  output logic [31:0]       srr1,
  output logic [ADDR_W-1:0] redirAddr,
  output logic              redirValid
);
  entryCtl_t ctl;

  exc_entry_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .takeExc(takeExc),
    .ctl(ctl), .redirValid(redirValid)
  );

  exc_entry_dpath #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vecOffset(vecOffset),
    .retAddr(retAddr), .msrIn(msrIn), .msrOut(msrOut), .srr0(srr0),
    .srr1(srr1), .redirAddr(redirAddr)
  );
endmodule

// File: rtl/exc_entry_save_chk.sv
module exc_entry_save_chk #(
  parameter int              ADDR_W  = 32,
  parameter int              VEC_W   = 20,
  parameter logic [ADDR_W-1:0] BASE_HI = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] BASE_LO = 32'h0000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              takeExc,
  input logic [VEC_W-1:0]  vecOffset,
  input logic [ADDR_W-1:0] retAddr,
  input logic [31:0]       msrIn,
  input logic [31:0]       msrOut,
  input logic [ADDR_W-1:0] srr0,
  input logic [31:0]       srr1,
  input logic [ADDR_W-1:0] redirAddr,
  input logic              redirValid
);
  // R2
  srr0_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> srr0 == $past(retAddr));
  // R3
  srr1_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> srr1 == {16'h0000, $past(msrIn[15:0])});
  // R4
  msr_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> (msrOut & 32'h0006_EF32) == 32'h0);
  // R5
  msr_endian_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> msrOut[0] == $past(msrIn[16]));
  // R7 R8
  redir_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> redirAddr == (($past(msrIn[6]) ? BASE_HI : BASE_LO)
                              + {{(ADDR_W-VEC_W){1'b0}}, $past(vecOffset)}));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirValid == $past(takeExc));
  // R10
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeExc |=> $stable(msrOut) && $stable(srr0) && $stable(srr1) && $stable(redirAddr));
endmodule

bind exc_entry_save exc_entry_save_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO)
) chk_i (
  .clk(clk), .rstN(rstN), .takeExc(takeExc), .vecOffset(vecOffset),
  .retAddr(retAddr), .msrIn(msrIn), .msrOut(msrOut), .srr0(srr0),
  .srr1(srr1), .redirAddr(redirAddr), .redirValid(redirValid)
);

// File: tb/exc_entry_save_tb.sv
module exc_entry_save_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        takeExc = 1'b0;
  logic [19:0] vecOffset = '0;
  logic [31:0] retAddr = '0;
  logic [31:0] msrIn = '0;
  logic [31:0] msrOut, srr0, srr1, redirAddr;
  logic        redirValid;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_save dut_i (
    .clk(clk), .rstN(rstN), .takeExc(takeExc), .vecOffset(vecOffset),
    .retAddr(retAddr), .msrIn(msrIn), .msrOut(msrOut), .srr0(srr0),
    .srr1(srr1), .redirAddr(redirAddr), .redirValid(redirValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected new machine state: clear R4 mask, LE (index 0) from ILE (index 16)
  function automatic logic [31:0] expMsr(input logic [31:0] m);
    logic [31:0] r;
    r = m & ~32'h0006_EF32;
    r[0] = m[16];
    return r;
  endfunction

  function automatic logic [31:0] expRedir(input logic [31:0] m, input logic [19:0] v);
    return (m[6] ? 32'hFFF0_0000 : 32'h0) + {12'h0, v};
  endfunction

  // one strobe; check all results in the cycle after, then the pulse end
  task automatic fireOne(input string tag, input logic [31:0] m,
                         input logic [31:0] ra, input logic [19:0] v);
    @(negedge clk);
    msrIn = m; retAddr = ra; vecOffset = v; takeExc = 1'b1;
    @(negedge clk);
    takeExc = 1'b0;
    chk("R2", {tag, " srr0"}, srr0, ra);
    chk("R3", {tag, " srr1"}, srr1, {16'h0, m[15:0]});
    chk("R4/R5/R6", {tag, " msrOut"}, msrOut, expMsr(m));
    chk(m[6] ? "R7" : "R8", {tag, " redirAddr"}, redirAddr, expRedir(m, v));
    chk("R9", {tag, " valid high"}, {31'h0, redirValid}, 32'h1);
    @(negedge clk);
    chk("R9", {tag, " valid low"}, {31'h0, redirValid}, 32'h0);
  endtask

  task automatic testReset();
    chk("R1", "msrOut", msrOut, 32'h0);
    chk("R1", "srr0", srr0, 32'h0);
    chk("R1", "srr1", srr1, 32'h0);
    chk("R1", "redirAddr", redirAddr, 32'h0);
    chk("R1", "redirValid", {31'h0, redirValid}, 32'h0);
  endtask

  task automatic testAllOnesHigh();
    fireOne("ones", 32'hFFFF_FFFF, 32'h0000_1234, 20'h01300);
    chk("R4", "ones cleared mask", msrOut & 32'h0006_EF32, 32'h0);
    chk("R7", "ones high base", redirAddr, 32'hFFF0_1300);
  endtask

  task automatic testPatternLow();
    // ILE clear, LE set, IP clear, ME set: LE must fall to zero
    fireOne("pattern", 32'hA5A5_1A5B & ~32'h0001_0040 | 32'h0000_1000,
            32'hDEAD_BEEC, 20'h01400);
    chk("R5", "pattern LE from ILE", {31'h0, msrOut[0]}, 32'h0);
    chk("R5", "pattern ME kept", {31'h0, msrOut[12]}, 32'h1);
    chk("R8", "pattern low base", redirAddr, 32'h0000_1400);
  endtask

  task automatic testPassThrough();
    // only unnamed bits set (big-endian 0-12, 24, 28, 29)
    fireOne("unnamed", 32'hFFF8_008C, 32'h0000_0100, 20'h00000);
    chk("R6", "unnamed kept", msrOut, 32'hFFF8_008C);
  endtask

  task automatic testMaxOffset();
    fireOne("maxoff", 32'h0001_0040, 32'h8000_0000, 20'hFFFFF);
    chk("R7", "max offset", redirAddr, 32'hFFFF_FFFF);
    chk("R5", "ILE kept and copied", {30'h0, msrOut[16], msrOut[0]}, 32'h3);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    msrIn = 32'h0000_0040; retAddr = 32'h1111_1110; vecOffset = 20'h00700; takeExc = 1'b1;
    @(negedge clk);
    chk("R9", "b2b first valid", {31'h0, redirValid}, 32'h1);
    chk("R9", "b2b first addr", redirAddr, 32'hFFF0_0700);
    msrIn = 32'h0000_8000; retAddr = 32'h2222_2220; vecOffset = 20'h00900;
    @(negedge clk);
    takeExc = 1'b0;
    chk("R9", "b2b second valid", {31'h0, redirValid}, 32'h1);
    chk("R9", "b2b second addr", redirAddr, 32'h0000_0900);
    chk("R2", "b2b second srr0", srr0, 32'h2222_2220);
    @(negedge clk);
    chk("R9", "b2b end", {31'h0, redirValid}, 32'h0);
  endtask

  task automatic testHold();
    logic [31:0] m0, s0, s1, r0;
    m0 = msrOut; s0 = srr0; s1 = srr1; r0 = redirAddr;
    @(negedge clk);
    msrIn = 32'h1234_5678; retAddr = 32'hCAFE_F00C; vecOffset = 20'hABCDE;
    repeat (3) @(negedge clk);
    chk("R10", "hold msrOut", msrOut, m0);
    chk("R10", "hold srr0", srr0, s0);
    chk("R10", "hold srr1", srr1, s1);
    chk("R10", "hold redirAddr", redirAddr, r0);
    chk("R10", "hold valid", {31'h0, redirValid}, 32'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllOnesHigh();
    testPatternLow();
    testPassThrough();
    testMaxOffset();
    testBackToBack();
    testHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule